// File: doc/BRIEF.md
# Parallel Bus Handshake Monitor

This block sits beside a shared parallel bus and only listens. Each clock edge it samples five control lines: the transfer-start line driven by the initiator, the initiator and target ready lines, the target halt line and the target claim line. From these it classifies every cycle as idle, address or data. It counts the beats moved in each transfer, one beat for every cycle in which both ready lines are asserted, and holds the beat total of the most recent finished transfer.

While watching, it checks five handshake rules and sets one sticky error bit for each rule that is broken. The rules cover a party that changes its lines after it has committed to a data phase, a transfer that fails to close correctly after its final beat, the start line coming back during the final data phase, and a ready strobe seen with no transfer open. The error vector stays set until a clear pulse arrives. A single summary output goes high while any bit is set.

The polarity of the bus pins is chosen by a parameter, and a second parameter chooses whether the beat counter saturates or wraps.

Top module: `pbmon_top`

## Requirements
- R1: During reset, `phase` reads 0 (idle), `err_vec` and `err_any` read 0, and `last_beats` reads 0. Reset is asynchronous and active low.
- R2: `phase` shows the class of the cycle sampled at the latest edge, using 0 for idle, 1 for address and 2 for data. With no transfer open, a cycle with start asserted is an address cycle, and any other cycle is idle. With a transfer open, a cycle is a data cycle unless start and initiator-ready are both negated, which makes it idle and closes the transfer. An address cycle is never followed by another address cycle.
- R3: A beat is a data cycle with both ready lines asserted. A transfer closes at its final data phase (start negated, initiator-ready asserted, and target-ready or halt asserted) or at an idle cycle. When it closes, `last_beats` takes that transfer's beat total, including a beat in the closing cycle. An address cycle restarts the count.
- R4: With SATURATE=1, the beat total stops at 2^CNT_W-1.
- R5: err_vec bit 0 is set when the previous cycle was a data cycle with initiator-ready asserted and without completion (completion means initiator-ready together with target-ready or halt), and initiator-ready or start now differs from that cycle.
- R6: err_vec bit 1 is set when the previous cycle was a data cycle with target-ready or halt asserted and initiator-ready negated, and claim, target-ready or halt now differs from that cycle.
- R7: err_vec bit 2 is set when initiator-ready is asserted in the cycle right after a final beat. After a final beat, an idle cycle and an immediate new address cycle are both legal.
- R8: err_vec bit 3 is set when start is asserted again after a data cycle that had start negated, initiator-ready asserted and no completion.
- R9: err_vec bit 4 is set when initiator-ready is asserted with start negated, no transfer open and no final beat in the previous cycle.
- R10: Error bits are sticky. A sampled clear pulse empties all bits, but a violation seen in that same cycle is still recorded. `err_any` is the OR of all bits.
- R11: With ACT_LOW=1 (the default), every bus pin is asserted when low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge samples |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_start | input | 1 | Transfer-start line driven by the initiator |
| bus_irdy | input | 1 | Initiator ready |
| bus_trdy | input | 1 | Target ready |
| bus_halt | input | 1 | Target halt request |
| bus_claim | input | 1 | Target claim |
| err_clr | input | 1 | Clear pulse for the error vector |
| phase | output | 2 | Class of the last sampled cycle |
| last_beats | output | CNT_W | Beat total of the latest finished transfer |
| err_vec | output | 5 | Sticky per-rule error bits |
| err_any | output | 1 | OR of the error bits |

## Verification
A phase tracker stuck in the wrong open or closed state shows up one edge later. It appears either as a wrong `phase` code or as a spurious-handshake bit set during a legal transfer. A beat counter that does not restart at an address cycle shows a wrong `last_beats` as soon as the next transfer closes. Lost history in the rule evaluator appears as a missing or extra error bit on the edge right after the offending cycle. Because every error bit is sticky, a false flag stays visible until the next clear.

// File: rtl/pbmon_pkg.sv
package pbmon_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ADDR = 2'd1,
      PH_DATA = 2'd2
   } phase_e;

   localparam int NUM_RULES = 5;
   localparam int RULE_INIT = 0;
   localparam int RULE_TGT  = 1;
   localparam int RULE_END  = 2;
   localparam int RULE_REFR = 3;
   localparam int RULE_SPUR = 4;

   typedef struct packed {
      logic start;
      logic i_rdy;
      logic t_rdy;
      logic t_halt;
      logic t_claim;
   } bus_t;
endpackage

// File: rtl/pbmon_norm.sv
module pbmon_norm
   import pbmon_pkg::*;
#(
   parameter bit ACT_LOW = 1'b1
) (
   input  logic [4:0] raw,
   output bus_t       b
);
   generate
      if (ACT_LOW) begin : g_low
         assign b = bus_t'(~raw);
      end else begin : g_high
         assign b = bus_t'(raw);
      end
   endgenerate
endmodule

// File: rtl/pbmon_phase.sv
module pbmon_phase
   import pbmon_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   input  logic   i_rdy,
   input  logic   t_rdy,
   input  logic   t_halt,
   output logic   busy,
   output logic   is_addr,
   output logic   is_data,
   output logic   closing,
   output phase_e phase_q
);
   phase_e cls;
   logic   done, busy_nxt;

   always_comb begin
      if (!busy) cls = start ? PH_ADDR : PH_IDLE;
      else       cls = (start | i_rdy) ? PH_DATA : PH_IDLE;
      done     = i_rdy & (t_rdy | t_halt);
      busy_nxt = (cls == PH_ADDR) | ((cls == PH_DATA) & ~(done & ~start));
   end

   assign is_addr = (cls == PH_ADDR);
   assign is_data = (cls == PH_DATA);
   assign closing = busy & ~busy_nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         phase_q <= PH_IDLE;
      end else begin
         busy    <= busy_nxt;
         phase_q <= cls;
      end
   end
endmodule

// File: rtl/pbmon_beats.sv
module pbmon_beats #(
   parameter int CNT_W    = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             beat,
   input  logic             closing,
   output logic [CNT_W-1:0] last_q
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] cnt_q, cnt_inc, cnt_nxt;

   generate
      if (SATURATE) begin : g_sat
         assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_ONE;
      end else begin : g_wrap
         assign cnt_inc = cnt_q + CNT_ONE;
      end
   endgenerate

   always_comb begin
      if (restart)   cnt_nxt = '0;
      else if (beat) cnt_nxt = cnt_inc;
      else           cnt_nxt = cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         last_q <= '0;
      end else begin
         cnt_q <= cnt_nxt;
         if (closing) last_q <= cnt_nxt;
      end
   end
endmodule

// File: rtl/pbmon_rules.sv
module pbmon_rules
   import pbmon_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  bus_t                 b,
   input  logic                 busy,
   input  logic                 is_data,
   output logic [NUM_RULES-1:0] viol
);
   bus_t p;
   logic p_data, done_p, fin_p, tgt_held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p      <= '0;
         p_data <= 1'b0;
      end else begin
         p      <= b;
         p_data <= is_data;
      end
   end

   always_comb begin
      done_p   = p.i_rdy & (p.t_rdy | p.t_halt);
      fin_p    = p_data & ~p.start & p.i_rdy & p.t_rdy;
      tgt_held = (b.t_claim == p.t_claim) & (b.t_rdy == p.t_rdy) & (b.t_halt == p.t_halt);
      viol            = '0;
      viol[RULE_INIT] = p_data & p.i_rdy & ~done_p &
                        ((b.i_rdy != p.i_rdy) | (b.start != p.start));
      viol[RULE_TGT]  = p_data & (p.t_rdy | p.t_halt) & ~p.i_rdy & ~tgt_held;
      viol[RULE_END]  = fin_p & b.i_rdy;
      viol[RULE_REFR] = p_data & ~p.start & p.i_rdy & ~done_p & b.start;
      viol[RULE_SPUR] = ~busy & ~b.start & b.i_rdy & ~fin_p;
   end
endmodule

// File: rtl/pbmon_top.sv
module pbmon_top
   import pbmon_pkg::*;
#(
   parameter bit ACT_LOW  = 1'b1,
   parameter int CNT_W    = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_start,
   input  logic                 bus_irdy,
   input  logic                 bus_trdy,
   input  logic                 bus_halt,
   input  logic                 bus_claim,
   input  logic                 err_clr,
   output logic [1:0]           phase,
   output logic [CNT_W-1:0]     last_beats,
   output logic [NUM_RULES-1:0] err_vec,
   output logic                 err_any
);
   generate
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt_w
         $error("pbmon_top: CNT_W must lie in 1..32");
      end
   endgenerate

   bus_t                 b;
   phase_e               phase_q;
   logic                 busy, is_addr, is_data, closing;
   logic [NUM_RULES-1:0] viol;
   logic [NUM_RULES-1:0] err_q;

   pbmon_norm #(.ACT_LOW(ACT_LOW)) u_norm (
      .raw ({bus_start, bus_irdy, bus_trdy, bus_halt, bus_claim}),
      .b   (b)
   );

   pbmon_phase u_phase (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (b.start),
      .i_rdy   (b.i_rdy),
      .t_rdy   (b.t_rdy),
      .t_halt  (b.t_halt),
      .busy    (busy),
      .is_addr (is_addr),
      .is_data (is_data),
      .closing (closing),
      .phase_q (phase_q)
   );

   pbmon_beats #(.CNT_W(CNT_W), .SATURATE(SATURATE)) u_beats (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (is_addr),
      .beat    (is_data & b.i_rdy & b.t_rdy),
      .closing (closing),
      .last_q  (last_beats)
   );

   pbmon_rules u_rules (
      .clk     (clk),
      .rst_n   (rst_n),
      .b       (b),
      .busy    (busy),
      .is_data (is_data),
      .viol    (viol)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= '0;
      else        err_q <= (err_clr ? '0 : err_q) | viol;
   end

   assign phase   = phase_q;
   assign err_vec = err_q;
   assign err_any = |err_q;
endmodule

// File: rtl/pbmon_chk.sv
module pbmon_chk #(
   parameter int NR = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          err_clr,
   input logic [NR-1:0] viol,
   input logic [NR-1:0] err_vec,
   input logic [1:0]    phase
);
   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !err_clr |=> ((err_vec & $past(err_vec)) == $past(err_vec))); // R10
   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (err_clr && viol == '0) |=> (err_vec == '0)); // R10
   AST_VIOL_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
      (viol != '0) |=> ((err_vec & $past(viol)) == $past(viol))); // R5
   AST_PHASE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      phase != 2'd3); // R2
   AST_ADDR_NOT_REPEATED: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == 2'd1) |=> (phase != 2'd1)); // R2
endmodule

bind pbmon_top pbmon_chk #(.NR(pbmon_pkg::NUM_RULES)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .err_clr (err_clr),
   .viol    (viol),
   .err_vec (err_vec),
   .phase   (phase)
);

// File: tb/sim_pbmon_top.sv
module sim_pbmon_top;
   localparam int CNT_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             bus_start = 1'b1, bus_irdy = 1'b1, bus_trdy = 1'b1;
   logic             bus_halt = 1'b1, bus_claim = 1'b1, err_clr = 1'b0;
   logic [1:0]       phase;
   logic [CNT_W-1:0] last_beats;
   logic [4:0]       err_vec;
   logic             err_any;
   int               n_chk = 0, n_err = 0;

   always #10 clk = ~clk;

   pbmon_top u0 (
      .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_irdy(bus_irdy),
      .bus_trdy(bus_trdy), .bus_halt(bus_halt), .bus_claim(bus_claim),
      .err_clr(err_clr), .phase(phase), .last_beats(last_beats),
      .err_vec(err_vec), .err_any(err_any)
   );

   // {start,irdy,trdy,halt,claim}, clear, phase, err_vec, last_beats
   localparam logic [16:0] VEC [0:33] = '{
      {5'b00000,1'b0,2'd0,5'b00000,4'd0},  // R2 idle
      {5'b10000,1'b0,2'd1,5'b00000,4'd0},  // R2 address
      {5'b11001,1'b0,2'd2,5'b00000,4'd0},  // target wait
      {5'b11101,1'b0,2'd2,5'b00000,4'd0},  // beat 1
      {5'b01101,1'b0,2'd2,5'b00000,4'd2},  // R3 final beat 2
      {5'b00000,1'b0,2'd0,5'b00000,4'd2},
      {5'b10000,1'b0,2'd1,5'b00000,4'd2},
      {5'b01101,1'b0,2'd2,5'b00000,4'd1},  // single beat final
      {5'b10000,1'b0,2'd1,5'b00000,4'd1},  // R7 back-to-back address
      {5'b11101,1'b0,2'd2,5'b00000,4'd1},
      {5'b01001,1'b0,2'd2,5'b00000,4'd1},
      {5'b01101,1'b0,2'd2,5'b00000,4'd2},
      {5'b00000,1'b0,2'd0,5'b00000,4'd2},
      {5'b01000,1'b0,2'd0,5'b10000,4'd2},  // R9 spurious
      {5'b00000,1'b1,2'd0,5'b00000,4'd2},  // R10 clear
      {5'b10000,1'b0,2'd1,5'b00000,4'd2},
      {5'b11001,1'b0,2'd2,5'b00000,4'd2},
      {5'b10001,1'b0,2'd2,5'b00001,4'd2},  // R5 irdy withdrawn
      {5'b01101,1'b0,2'd2,5'b00001,4'd1},
      {5'b01001,1'b0,2'd0,5'b00101,4'd1},  // R7 irdy after final beat
      {5'b00000,1'b1,2'd0,5'b00000,4'd1},
      {5'b10000,1'b0,2'd1,5'b00000,4'd1},
      {5'b10101,1'b0,2'd2,5'b00000,4'd1},
      {5'b10001,1'b0,2'd2,5'b00010,4'd1},  // R6 trdy withdrawn
      {5'b01101,1'b0,2'd2,5'b00010,4'd1},
      {5'b00000,1'b1,2'd0,5'b00000,4'd1},
      {5'b10000,1'b0,2'd1,5'b00000,4'd1},
      {5'b01001,1'b0,2'd2,5'b00000,4'd1},
      {5'b11001,1'b0,2'd2,5'b01001,4'd1},  // R8 start reasserted
      {5'b01101,1'b0,2'd2,5'b01001,4'd1},
      {5'b00000,1'b1,2'd0,5'b00000,4'd1},
      {5'b10000,1'b0,2'd1,5'b00000,4'd1},
      {5'b01011,1'b0,2'd2,5'b00000,4'd0},  // R3 halt ends with no beat
      {5'b00000,1'b0,2'd0,5'b00000,4'd0}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // R11: pins are asserted low, so the bench inverts the asserted-sense value
   task automatic drive(input logic [4:0] sig, input logic clr);
      @(negedge clk);
      {bus_start, bus_irdy, bus_trdy, bus_halt, bus_claim} = ~sig;
      err_clr = clr;
      @(posedge clk);
      #2;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin : main
      repeat (3) @(posedge clk);
      #2;
      check("R1 phase", phase, 0);
      check("R1 err_vec", err_vec, 0);
      check("R1 err_any", err_any, 0);
      check("R1 last_beats", last_beats, 0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < 34; i++) begin
         drive(VEC[i][16:12], VEC[i][11]);
         check($sformatf("R2 phase step %0d", i), phase, VEC[i][10:9]);
         check($sformatf("R5-R9 err_vec step %0d", i), err_vec, VEC[i][8:4]);
         check($sformatf("R10 err_any step %0d", i), err_any, VEC[i][8:4] != 0);
         check($sformatf("R3 last_beats step %0d", i), last_beats, VEC[i][3:0]);
      end

      // R10: clear in the same cycle as a new violation keeps that violation
      drive(5'b01000, 1'b0);
      check("R9 spurious again", err_vec, 5'b10000);
      drive(5'b01000, 1'b1);
      check("R10 clear with violation", err_vec, 5'b10000);
      drive(5'b00000, 1'b1);
      check("R10 clear alone", err_vec, 5'b00000);

      // R3: idle cycle closes a transfer
      drive(5'b10000, 1'b0);
      drive(5'b11101, 1'b0);
      drive(5'b00000, 1'b0);
      check("R3 idle close phase", phase, 0);
      check("R3 idle close beats", last_beats, 1);
      check("R3 idle close no error", err_vec, 0);

      // R4: saturation of the beat total
      drive(5'b10000, 1'b0);
      for (int k = 0; k < 300; k++) drive(5'b11101, 1'b0);
      drive(5'b01101, 1'b0);
      drive(5'b00000, 1'b0);
      check("R4 saturated total", last_beats, 255);
      check("R4 no error", err_vec, 0);

      // R1: reset in mid run empties the errors
      drive(5'b01000, 1'b0);
      check("R9 before reset", err_vec, 5'b10000);
      @(negedge clk);
      rst_n = 1'b0;
      #2;
      check("R1 reset err_vec", err_vec, 0);
      check("R1 reset last_beats", last_beats, 0);
      check("R1 reset phase", phase, 0);
      @(negedge clk);
      rst_n = 1'b1;
      drive(5'b00000, 1'b0);
      check("R1 idle after reset", phase, 0);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule